// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt lines into one request to a processor. Each line is sampled on every clock and latched into a status register. Two things gate a latched bit before it can raise the request: an enable mask, and a nesting level that blocks the current priority and every priority below it. Index 0 has the highest priority. The request output carries a global master enable.

Each source can be placed in fast delivery. When a fast source wins, the block captures that source's vector address and offers it on a valid/acknowledge output.

- The address is held stable until the processor returns a one-cycle acknowledge.
- That acknowledge clears the winning status bit.
- Back-pressure is simply the absence of the acknowledge: the offered vector never changes while it waits.

Software can inject interrupts by writing the status register, which allows testing without any device. This stays possible until a write-once hardware-enable bit is set.

Registers sit on a plain 32-bit write/read port with byte addresses. The control words are:

| Byte address | Register |
|---|---|
| 0x00 | status |
| 0x04 | pending (status AND enable) |
| 0x08 | enable |
| 0x0C | acknowledge |
| 0x10 | master |
| 0x14 | mode |
| 0x18 | level |
| 0x1C | winner |

In the master register, bit 0 is the master enable and bit 1 is the hardware enable. In the winner register, bit 31 means a request is eligible and the low 5 bits hold the winning index. Vector registers sit at byte 0x100 + 4 × index. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among eligible sources the lowest index wins. The winner register (0x1C) reports bit 31 = 1 and the index in bits [4:0]; it reads 0 when no source is eligible.
- R2: A disabled source still latches its status bit, but it causes no request and no pending bit (0x04) until its enable bit (0x08) is set.
- R3: Writing ones to acknowledge (0x0C) clears those status bits. Writing back the value read from status clears every bit that was read.
- R4: Master bit 1 (hardware enable) can be set but never cleared by software. Once it is set, writes to status are ignored, while input lines still latch.
- R5: While the hardware enable is clear, a write to status (0x00) sets the written bits.
- R6: A winner whose mode bit (0x14) is 1 has its vector address captured one cycle after it wins. The address is offered with vec_valid_o and held unchanged until vec_ack_i. The acknowledge cycle clears that source's status bit, and vec_valid_o falls on the next cycle.
- R7: Each source's 32-bit vector register is readable and writable at byte address 0x100 + 4 × index.
- R8: The level register (0x18) resets to 0xFFFFFFFF. After N is written, only sources with index below N can raise the request.
- R9: When a mode bit changes from 1 to 0, that source's vector register is reloaded with the default vector (parameter, 0x10).
- R10: irq_o is high exactly when master bit 0 is set and some bit of status AND enable AND level mask is set.
- R11: An input seen high in the same cycle as an acknowledge of its bit leaves the status bit set.
- R12: A winner in normal mode (mode bit 0) never raises vec_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 32 | Interrupt lines, latched while high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Fast vector offered |
| vec_addr_o | output | 32 | Fast vector address |
| vec_ack_i | input | 1 | Processor acknowledge of the fast vector |

## Verification
Two clearing paths can fall in the same cycle as a new event on the same bit:

- An acknowledge register write landing together with a rising input line.
- A processor vector acknowledge landing while other lines latch.

The bench drives an input high in exactly the cycle its acknowledge write is applied and then reads status back, expecting the bit to survive. It also acknowledges a held fast vector while a higher-priority normal source is pending. After that it judges three things: only the fast bit cleared, the request stays up, and no new vector is offered for the normal source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW = 32;
  localparam int AW = 9;
  localparam logic [6:0] W_STAT = 7'd0;
  localparam logic [6:0] W_PEND = 7'd1;
  localparam logic [6:0] W_EN   = 7'd2;
  localparam logic [6:0] W_ACK  = 7'd3;
  localparam logic [6:0] W_MST  = 7'd4;
  localparam logic [6:0] W_MODE = 7'd5;
  localparam logic [6:0] W_LVL  = 7'd6;
  localparam logic [6:0] W_WIN  = 7'd7;
  localparam logic [6:0] W_VEC0 = 7'd64;
  localparam int MST_ME = 0;
  localparam int MST_HE = 1;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_vec_table.sv
module irqc_vec_table #(
  parameter int          N       = 32,
  parameter int          DW      = 32,
  parameter int          IW      = (N > 1) ? $clog2(N) : 1,
  parameter logic [31:0] DEF_VEC = 32'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vec,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  to_normal,
  output logic [DW-1:0] vec_q [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                              vec_q[g] <= DW'(DEF_VEC);
      else if (to_normal[g])                   vec_q[g] <= DW'(DEF_VEC);
      else if (wr_vec && (wr_idx == IW'(g)))   vec_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/irqc_fast_hold.sv
module irqc_fast_hold #(
  parameter int N  = 32,
  parameter int DW = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] win_idx,
  input  logic [DW-1:0] win_vec,
  input  logic          cpu_ack,
  output logic          hold_vld,
  output logic [DW-1:0] hold_vec,
  output logic [N-1:0]  done_clr
);
  logic [IW-1:0] hold_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_idx <= '0;
      hold_vec <= '0;
    end else if (hold_vld && cpu_ack) begin
      hold_vld <= 1'b0;
    end else if (!hold_vld && take) begin
      hold_vld <= 1'b1;
      hold_idx <= win_idx;
      hold_vec <= win_vec;
    end
  end

  assign done_clr = (hold_vld && cpu_ack) ? (N'(1) << hold_idx) : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter logic [31:0] DEF_VEC = 32'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] irq_src_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          vec_valid_o,
  output logic [DW-1:0] vec_addr_o,
  input  logic          vec_ack_i
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [6:0]      word;
  logic            is_vec;
  logic [IW-1:0]   vidx;
  logic            we_stat, we_en, we_ack, we_mst, we_mode, we_lvl, we_vec;
  logic [NSRC-1:0] status_q, en_q, mode_q, lvl_mask, elig, set_m, clr_m, done_clr, to_normal;
  logic [DW-1:0]   lvl_q;
  logic            me_q, he_q, any;
  logic [IW-1:0]   win_idx;
  logic [DW-1:0]   vec_q [NSRC];
  logic            take;
  logic [NSRC-1:0] wbits;

  assign word   = reg_addr_i[AW-1:2];
  assign is_vec = (word >= W_VEC0) && ((word - W_VEC0) < 7'(NSRC));
  assign vidx   = IW'(word - W_VEC0);
  assign wbits  = reg_wdata_i[NSRC-1:0];

  assign we_stat = reg_we_i && (word == W_STAT);
  assign we_en   = reg_we_i && (word == W_EN);
  assign we_ack  = reg_we_i && (word == W_ACK);
  assign we_mst  = reg_we_i && (word == W_MST);
  assign we_mode = reg_we_i && (word == W_MODE);
  assign we_lvl  = reg_we_i && (word == W_LVL);
  assign we_vec  = reg_we_i && is_vec;

  // a set from a line or injection always beats a clear in the same cycle
  assign set_m = irq_src_i | ((we_stat && !he_q) ? wbits : '0);
  assign clr_m = (we_ack ? wbits : '0) | done_clr;
  assign to_normal = we_mode ? (mode_q & ~wbits) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
      mode_q   <= '0;
      lvl_q    <= '1;
      me_q     <= 1'b0;
      he_q     <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_m) | set_m;
      if (we_en)   en_q   <= wbits;
      if (we_mode) mode_q <= wbits;
      if (we_lvl)  lvl_q  <= reg_wdata_i;
      if (we_mst) begin
        me_q <= reg_wdata_i[MST_ME];
        he_q <= he_q | reg_wdata_i[MST_HE];
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    assign lvl_mask[g] = lvl_q > DW'(g);
  end

  assign elig = status_q & en_q & lvl_mask;

  irqc_prio_enc #(.N(NSRC), .IW(IW)) u_enc (
    .req (elig),
    .any (any),
    .idx (win_idx)
  );

  assign irq_o = me_q && any;
  assign take  = irq_o && mode_q[win_idx];

  irqc_vec_table #(.N(NSRC), .DW(DW), .IW(IW), .DEF_VEC(DEF_VEC)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_vec    (we_vec),
    .wr_idx    (vidx),
    .wdata     (reg_wdata_i),
    .to_normal (to_normal),
    .vec_q     (vec_q)
  );

  irqc_fast_hold #(.N(NSRC), .DW(DW), .IW(IW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .win_idx  (win_idx),
    .win_vec  (vec_q[win_idx]),
    .cpu_ack  (vec_ack_i),
    .hold_vld (vec_valid_o),
    .hold_vec (vec_addr_o),
    .done_clr (done_clr)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (word)
      W_STAT: reg_rdata_o[NSRC-1:0] = status_q;
      W_PEND: reg_rdata_o[NSRC-1:0] = status_q & en_q;
      W_EN:   reg_rdata_o[NSRC-1:0] = en_q;
      W_MST:  begin
        reg_rdata_o[MST_ME] = me_q;
        reg_rdata_o[MST_HE] = he_q;
      end
      W_MODE: reg_rdata_o[NSRC-1:0] = mode_q;
      W_LVL:  reg_rdata_o = lvl_q;
      W_WIN:  begin
        reg_rdata_o[DW-1]   = any;
        reg_rdata_o[IW-1:0] = any ? win_idx : '0;
      end
      default: if (is_vec) reg_rdata_o = vec_q[vidx];
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC = 32,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_src_i,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] en_q,
  input logic [31:0]     lvl_q,
  input logic            me_q,
  input logic            he_q,
  input logic [IW-1:0]   win_idx,
  input logic            irq_o,
  input logic            vec_valid_o,
  input logic [31:0]     vec_addr_o,
  input logic            vec_ack_i
);
  assert_set_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_src_i) |=> ((status_q & $past(irq_src_i)) == $past(irq_src_i)));

  assert_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> me_q);

  assert_he_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    he_q |=> he_q);

  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ack_i) |=> (vec_valid_o && $stable(vec_addr_o)));

  assert_vec_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_ack_i) |=> !vec_valid_o);

  assert_lvl_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (32'(win_idx) < lvl_q));

  assert_win_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_q[win_idx] && en_q[win_idx]));
endmodule

bind prio_irq_ctrl irqc_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_src_i   (irq_src_i),
  .status_q    (status_q),
  .en_q        (en_q),
  .lvl_q       (lvl_q),
  .me_q        (me_q),
  .he_q        (he_q),
  .win_idx     (win_idx),
  .irq_o       (irq_o),
  .vec_valid_o (vec_valid_o),
  .vec_addr_o  (vec_addr_o),
  .vec_ack_i   (vec_ack_i)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        vec_valid;
  logic [31:0] vec_addr;
  logic        vec_ack = 1'b0;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  localparam logic [8:0] A_STAT = 9'h000, A_PEND = 9'h004, A_EN = 9'h008, A_ACK = 9'h00C;
  localparam logic [8:0] A_MST = 9'h010, A_MODE = 9'h014, A_LVL = 9'h018, A_WIN = 9'h01C;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .vec_valid_o(vec_valid), .vec_addr_o(vec_addr), .vec_ack_i(vec_ack)
  );

  function automatic logic [8:0] vaddr(int i);
    return 9'(32'h100 + 4 * i);
  endfunction

  function automatic logic [31:0] exp_win(logic [31:0] st, logic [31:0] en, logic [31:0] lv);
    logic [31:0] r = '0;
    for (int i = 31; i >= 0; i--)
      if (st[i] && en[i] && (lv > 32'(i))) r = 32'h8000_0000 | 32'(i);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] p);
    @(negedge clk);
    irq_src = p;
    @(negedge clk);
    irq_src = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st, en, lv, pat;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    #1;
    chk("R10 reset irq", 32'(irq), 0);
    chk("R6 reset vec_valid", 32'(vec_valid), 0);
    rd(A_LVL, v);  chk("R8 level reset", v, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R3 status reset", v, 0);

    // R7 vector table placement
    wr(vaddr(0), 32'hA000_0000);
    wr(vaddr(13), 32'hA000_0D00);
    wr(vaddr(31), 32'hA000_1F00);
    rd(vaddr(0), v);  chk("R7 vec0", v, 32'hA000_0000);
    rd(vaddr(13), v); chk("R7 vec13", v, 32'hA000_0D00);
    rd(vaddr(31), v); chk("R7 vec31", v, 32'hA000_1F00);

    // R5 injection, R2 disabled latching
    wr(A_STAT, 32'h0000_00F0);
    rd(A_STAT, v); chk("R5 injected status", v, 32'h0000_00F0);
    wr(A_MST, 32'h1);
    rd(A_PEND, v); chk("R2 pending while disabled", v, 0);
    chk("R2 no irq while disabled", 32'(irq), 0);
    wr(A_EN, 32'h0000_0020);
    rd(A_WIN, v); chk("R2 enabled source wins", v, 32'h8000_0005);
    chk("R10 irq on", 32'(irq), 1);
    wr(A_EN, 32'h0000_00F0);
    rd(A_WIN, v); chk("R1 lowest index wins", v, 32'h8000_0004);

    // R3 acknowledge
    wr(A_ACK, 32'h0000_0010);
    rd(A_STAT, v); chk("R3 single ack", v, 32'h0000_00E0);
    wr(A_ACK, v);
    rd(A_STAT, v); chk("R3 writeback clears all", v, 0);

    // R10 master enable gating
    wr(A_STAT, 32'h0000_0040);
    wr(A_MST, 32'h0);
    chk("R10 master off", 32'(irq), 0);
    wr(A_MST, 32'h1);
    chk("R10 master on", 32'(irq), 1);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R11 set beats clear in the same cycle
    @(negedge clk);
    irq_src = 32'h4; reg_we = 1'b1; reg_addr = A_ACK; reg_wdata = 32'h4;
    @(negedge clk);
    irq_src = '0; reg_we = 1'b0;
    rd(A_STAT, v); chk("R11 set wins over ack", v, 32'h4);
    wr(A_ACK, 32'h4);
    rd(A_STAT, v); chk("R11 later ack clears", v, 0);

    // R8 level blocking
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_STAT, 32'h0000_0044);
    wr(A_LVL, 32'd4);
    rd(A_WIN, v); chk("R8 below level wins", v, 32'h8000_0002);
    wr(A_ACK, 32'h4);
    chk("R8 index above level blocked", 32'(irq), 0);
    rd(A_WIN, v); chk("R8 winner empty", v, 0);
    wr(A_LVL, 32'hFFFF_FFFF);
    rd(A_WIN, v); chk("R8 unblocked", v, 32'h8000_0006);
    wr(A_ACK, 32'hFFFF_FFFF);

    // random priority and level mix (R1, R10)
    for (int k = 0; k < 40; k++) begin
      pat = $urandom;
      en  = $urandom;
      lv  = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : 32'($urandom % 33);
      wr(A_ACK, 32'hFFFF_FFFF);
      wr(A_EN, en);
      wr(A_LVL, lv);
      pulse(pat);
      st = exp_win(pat, en, lv);
      rd(A_WIN, v); chk("R1 random winner", v, st);
      chk("R10 random irq", 32'(irq), 32'(st[31]));
    end
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_LVL, 32'hFFFF_FFFF);

    // R6 fast delivery, R12 normal source does not offer a vector
    wr(A_EN, 32'h0000_0028);
    wr(vaddr(5), 32'h1234_5600);
    wr(A_MODE, 32'h0000_0020);
    pulse(32'h20);
    @(negedge clk);
    chk("R6 vec valid", 32'(vec_valid), 1);
    chk("R6 vec addr", vec_addr, 32'h1234_5600);
    pulse(32'h08);
    repeat (2) @(negedge clk);
    chk("R6 held stable", vec_addr, 32'h1234_5600);
    chk("R6 still valid", 32'(vec_valid), 1);
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    chk("R6 released", 32'(vec_valid), 0);
    rd(A_STAT, v); chk("R6 ack cleared only fast bit", v, 32'h08);
    chk("R12 normal winner keeps irq", 32'(irq), 1);
    repeat (2) @(negedge clk);
    chk("R12 no vector for normal", 32'(vec_valid), 0);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R9 default vector reload
    wr(A_MODE, 32'h0);
    rd(vaddr(5), v); chk("R9 reload on normal", v, 32'h10);
    rd(vaddr(13), v); chk("R9 untouched entry", v, 32'hA000_0D00);

    // R4 write-once hardware enable
    wr(A_MST, 32'h3);
    wr(A_MST, 32'h1);
    rd(A_MST, v); chk("R4 hw enable sticky", v, 32'h3);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); chk("R4 injection ignored", v, 0);
    pulse(32'h0000_0100);
    rd(A_STAT, v); chk("R4 lines still latch", v, 32'h0000_0100);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule